// File: doc/BRIEF.md
# Multi-channel auxiliary ADC sequencer

This block lets software sample any of sixteen analog channels through one shared converter. Software writes a register to raise a channel's trigger bit. The block queues that request and, when the converter is powered and free, launches one conversion for the channel. The 12-bit result is then stored, together with a ready flag, in the channel's own data register. A global busy flag shows whether any request is still queued or in flight. A power-enable bit holds all launches back without losing the queued requests.

The handshake on each channel is level-based. Software drops a channel's trigger bit, which clears that channel's ready flag. It then raises the bit again and polls until ready comes back. A ready flag seen after a fresh rise therefore always belongs to a conversion launched after that rise. When several channels are queued, the lowest-numbered one is served first, one conversion at a time.

A four-state machine drives the converter:
- IDLE waits for a queued request while power is on (transition *grant*).
- LAUNCH sends a one-cycle start pulse with the channel number (transition *launched*).
- WAIT holds until the converter's done pulse (transition *done*).
- COMMIT writes the captured result into the register file and returns to IDLE (transition *retire*).

Top module: `aux_adc_seq`

## Requirements
- R1: After reset, every mapped register reads 0 and `conv_start` is low.
- R2: The trigger register sits at offset 0x04, is read/write and resets to 0. A 0-to-1 change of bit N queues exactly one conversion of channel N.
- R3: Channel N's data register sits at offset 0x14 + 4*N. It returns the last stored result in bits 11:0 and the ready flag in bit 12, with all other bits 0. Bus writes to it change nothing.
- R4: Writing 0 to trigger bit N clears channel N's ready flag by the next cycle. If channel N's request is still queued, the same write withdraws it, and no conversion of channel N is launched.
- R5: Ready for channel N rises only when a conversion of channel N, launched after the latest trigger rise, is committed. If the trigger bit drops while that conversion is in flight, its result is discarded, and the data field and ready flag stay as the drop left them.
- R6: Bit 0 of the status register at offset 0x10 reads 1 while any request is queued or a conversion is in flight, and 0 otherwise.
- R7: The power register at offset 0x94 stores only bit 14; its other bits read 0. While bit 14 is 0, no conversion is launched and queued requests remain queued.
- R8: Queued requests are served one at a time, lowest channel number first. A queued request is removed only by its launch or by withdrawal.
- R9: Each conversion produces a `conv_start` pulse exactly one cycle wide, with `conv_ch` carrying the channel number. The result is taken from `conv_data` in the cycle in which `conv_done` is high.
- R10: Reads of any offset not listed above, including misaligned ones, return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte offset for reads and writes |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| conv_start | output | 1 | One-cycle launch pulse to the converter |
| conv_ch | output | 4 | Channel number of the launched conversion |
| conv_done | input | 1 | Converter completion pulse |
| conv_data | input | 12 | Converter result, valid while `conv_done` is high |

## Verification
The assertions assume that the converter raises `conv_done` only after it has received a start pulse, and once per start. The bench's converter model follows this rule. It answers each start with a single done pulse after a programmable latency, and it never raises done at any other time. The assertions also assume that bus writes are one-cycle strobes with a stable address. The bench drives every write on the falling edge and holds it for exactly one cycle. The in-flight withdrawal case stretches the converter latency, so that the drop lands well inside the WAIT state.

// File: rtl/aux_adc_pkg.sv
package aux_adc_pkg;

    // Register byte offsets and field positions
    localparam int OFS_TRIG   = 'h04;
    localparam int OFS_STAT   = 'h10;
    localparam int OFS_DATA   = 'h14;
    localparam int OFS_PWR    = 'h94;
    localparam int RDY_BIT    = 12;
    localparam int PWR_BIT    = 14;
    localparam int BUSY_BIT   = 0;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_LAUNCH = 2'd1,
        SEQ_WAIT   = 2'd2,
        SEQ_COMMIT = 2'd3
    } seq_state_e;

endpackage

// File: rtl/adcseq_arbiter.sv
module adcseq_arbiter #(
    parameter int NUM_CH = 16,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] req,
    output logic              pick_vld,
    output logic [CH_W-1:0]   pick_ch
);

    // Fixed priority: scan from the top so the lowest set index wins.
    always_comb begin
        pick_vld = |req;
        pick_ch  = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (req[i]) begin
                pick_ch = CH_W'(i);
            end
        end
    end

endmodule

// File: rtl/adcseq_fsm.sv
module adcseq_fsm
    import aux_adc_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int CH_W   = $clog2(NUM_CH),
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_en,
    input  logic [NUM_CH-1:0] req,
    input  logic              pick_vld,
    input  logic [CH_W-1:0]   pick_ch,
    output logic              grant_vld,
    output logic [CH_W-1:0]   grant_ch,
    output logic              conv_start,
    output logic [CH_W-1:0]   conv_ch,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    output logic              commit_we,
    output logic [CH_W-1:0]   commit_ch,
    output logic [DATA_W-1:0] commit_data,
    output logic              in_flight
);

    localparam logic [NUM_CH-1:0] ONE_HOT0 = NUM_CH'(1);

    seq_state_e state_q, state_d;
    logic [CH_W-1:0]   active_q;
    logic [DATA_W-1:0] result_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:   if (pwr_en && pick_vld) state_d = SEQ_LAUNCH;  // grant
            SEQ_LAUNCH: state_d = SEQ_WAIT;                            // launched
            SEQ_WAIT:   if (conv_done) state_d = SEQ_COMMIT;           // done
            SEQ_COMMIT: state_d = SEQ_IDLE;                            // retire
            default:    state_d = SEQ_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Channel and result capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= '0;
            result_q <= '0;
        end else begin
            if (grant_vld) begin
                active_q <= pick_ch;
            end
            if (state_q == SEQ_WAIT && conv_done) begin
                result_q <= conv_data;
            end
        end
    end

    // Outputs
    always_comb begin
        grant_vld  = 1'b0;
        conv_start = 1'b0;
        commit_we  = 1'b0;
        unique case (state_q)
            SEQ_IDLE:   grant_vld  = pwr_en && pick_vld;
            SEQ_LAUNCH: conv_start = 1'b1;
            SEQ_WAIT:   ;
            SEQ_COMMIT: commit_we  = 1'b1;
            default:    ;
        endcase
    end

    assign grant_ch    = pick_ch;
    assign conv_ch     = active_q;
    assign commit_ch   = active_q;
    assign commit_data = result_q;
    assign in_flight   = (state_q != SEQ_IDLE);

    // R7: a launch only follows a cycle with power enabled
    p_power_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> $past(pwr_en));

    // R9: the launch pulse is one cycle wide
    p_start_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R9: a commit always follows a done from the converter
    p_commit_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        commit_we |-> $past(conv_done));

    // R8: the granted channel is queued and no lower channel is queued
    p_lowest_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld |-> (req[grant_ch] &&
                       ((req & ((ONE_HOT0 << grant_ch) - ONE_HOT0)) == '0)));

endmodule

// File: rtl/adcseq_regs.sv
module adcseq_regs
    import aux_adc_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int CH_W   = $clog2(NUM_CH),
    parameter int DATA_W = 12,
    parameter int ADDR_W = 8,
    parameter int BUS_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              busy,
    input  logic              grant_vld,
    input  logic [CH_W-1:0]   grant_ch,
    input  logic              commit_we,
    input  logic [CH_W-1:0]   commit_ch,
    input  logic [DATA_W-1:0] commit_data,
    output logic [NUM_CH-1:0] pend,
    output logic              pwr_en
);

    localparam logic [ADDR_W-1:0] A_TRIG = ADDR_W'(OFS_TRIG);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_PWR  = ADDR_W'(OFS_PWR);

    logic [NUM_CH-1:0]             trig_q, trig_d, rise, fall;
    logic [NUM_CH-1:0]             pend_q, live_q, rdy_q, hit, take;
    logic [NUM_CH-1:0][DATA_W-1:0] res_q;
    logic                          pwr_q;
    logic                          trig_wr, pwr_wr;

    assign trig_wr = bus_wr && (bus_addr == A_TRIG);
    assign pwr_wr  = bus_wr && (bus_addr == A_PWR);

    always_comb begin
        trig_d = trig_wr ? bus_wdata[NUM_CH-1:0] : trig_q;
        rise   = trig_d & ~trig_q;
        fall   = trig_q & ~trig_d;
        for (int n = 0; n < NUM_CH; n++) begin
            hit[n]  = grant_vld && (grant_ch == CH_W'(n));
            take[n] = commit_we && (commit_ch == CH_W'(n)) && live_q[n] && trig_d[n];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_q <= '0;
            pwr_q  <= 1'b0;
            pend_q <= '0;
            live_q <= '0;
            rdy_q  <= '0;
            res_q  <= '0;
        end else begin
            trig_q <= trig_d;
            if (pwr_wr) begin
                pwr_q <= bus_wdata[PWR_BIT];
            end
            for (int n = 0; n < NUM_CH; n++) begin
                // queued request: set on rise, removed by launch or withdrawal
                if (rise[n]) begin
                    pend_q[n] <= 1'b1;
                end else if (fall[n] || hit[n]) begin
                    pend_q[n] <= 1'b0;
                end
                // conversion in flight still owned by the current trigger
                if (fall[n]) begin
                    live_q[n] <= 1'b0;
                end else if (hit[n]) begin
                    live_q[n] <= 1'b1;
                end else if (commit_we && commit_ch == CH_W'(n)) begin
                    live_q[n] <= 1'b0;
                end
                // ready flag and result field
                if (!trig_d[n]) begin
                    rdy_q[n] <= 1'b0;
                end else if (take[n]) begin
                    rdy_q[n] <= 1'b1;
                end
                if (take[n]) begin
                    res_q[n] <= commit_data;
                end
            end
        end
    end

    // Read mux; unmapped offsets return zero
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_TRIG) begin
            bus_rdata[NUM_CH-1:0] = trig_q;
        end else if (bus_addr == A_STAT) begin
            bus_rdata[BUSY_BIT] = busy;
        end else if (bus_addr == A_PWR) begin
            bus_rdata[PWR_BIT] = pwr_q;
        end else begin
            for (int n = 0; n < NUM_CH; n++) begin
                if (bus_addr == ADDR_W'(OFS_DATA + 4 * n)) begin
                    bus_rdata[DATA_W-1:0] = res_q[n];
                    bus_rdata[RDY_BIT]    = rdy_q[n];
                end
            end
        end
    end

    assign pend   = pend_q;
    assign pwr_en = pwr_q;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        // R4: writing zero to a trigger bit clears that channel's ready flag
        p_clear_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (trig_wr && !bus_wdata[g]) |=> !rdy_q[g]);

        // R5: ready rises only on a commit to this channel
        p_ready_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rdy_q[g]) |-> $past(commit_we && commit_ch == CH_W'(g)));

        // R3: the result field changes only on a commit to this channel
        p_data_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !(commit_we && commit_ch == CH_W'(g)) |=> $stable(res_q[g]));

        // R8: a queued request survives unless launched or withdrawn
        p_no_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_q[g] && trig_d[g] && !hit[g]) |=> pend_q[g]);
    end

endmodule

// File: rtl/aux_adc_seq.sv
module aux_adc_seq
    import aux_adc_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int DATA_W = 12,
    parameter int ADDR_W = 8,
    parameter int BUS_W  = 32,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              conv_start,
    output logic [CH_W-1:0]   conv_ch,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data
);

    logic [NUM_CH-1:0] pend;
    logic              pwr_en, busy, in_flight;
    logic              pick_vld, grant_vld, commit_we;
    logic [CH_W-1:0]   pick_ch, grant_ch, commit_ch;
    logic [DATA_W-1:0] commit_data;

    assign busy = (|pend) || in_flight;

    adcseq_regs #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .BUS_W  (BUS_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .busy        (busy),
        .grant_vld   (grant_vld),
        .grant_ch    (grant_ch),
        .commit_we   (commit_we),
        .commit_ch   (commit_ch),
        .commit_data (commit_data),
        .pend        (pend),
        .pwr_en      (pwr_en)
    );

    adcseq_arbiter #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W)
    ) u_arb (
        .req      (pend),
        .pick_vld (pick_vld),
        .pick_ch  (pick_ch)
    );

    adcseq_fsm #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W),
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwr_en      (pwr_en),
        .req         (pend),
        .pick_vld    (pick_vld),
        .pick_ch     (pick_ch),
        .grant_vld   (grant_vld),
        .grant_ch    (grant_ch),
        .conv_start  (conv_start),
        .conv_ch     (conv_ch),
        .conv_done   (conv_done),
        .conv_data   (conv_data),
        .commit_we   (commit_we),
        .commit_ch   (commit_ch),
        .commit_data (commit_data),
        .in_flight   (in_flight)
    );

    // R6: a launch is always reported as busy
    p_busy_on_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> busy);

    // R7: power off blocks any new grant
    p_no_grant_unpowered_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en |-> !grant_vld);

endmodule

// File: tb/aux_adc_seq_bench.sv
module aux_adc_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        conv_start;
    logic [3:0]  conv_ch;
    logic        conv_done = 1'b0;
    logic [11:0] conv_data = '0;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // converter model state
    int        lat = 6;
    int        salt = 0;
    int        cnt = 0;
    bit        m_busy = 0;
    logic [3:0] m_ch = '0;
    logic [3:0] start_log [64];
    int        n_starts = 0;
    int        start_run = 0;
    int        max_run = 0;

    always #4 clk = ~clk;   // 125 MHz

    aux_adc_seq u_aux_adc_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .conv_start (conv_start),
        .conv_ch    (conv_ch),
        .conv_done  (conv_done),
        .conv_data  (conv_data)
    );

    function automatic logic [11:0] exp_data(int ch, int s);
        return 12'((ch * 257 + s) & 'hFFF);
    endfunction

    // converter model: one done pulse per start after lat cycles
    always @(posedge clk) begin
        conv_done <= 1'b0;
        if (m_busy) begin
            if (cnt == 0) begin
                conv_done <= 1'b1;
                conv_data <= exp_data(int'(m_ch), salt);
                m_busy    <= 0;
            end else begin
                cnt <= cnt - 1;
            end
        end
        if (rst_n && conv_start) begin
            m_busy <= 1;
            m_ch   <= conv_ch;
            cnt    <= lat;
            start_log[n_starts % 64] <= conv_ch;
            n_starts <= n_starts + 1;
            start_run <= start_run + 1;
            if (start_run + 1 > max_run) max_run <= start_run + 1;
        end else begin
            start_run <= 0;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [7:0] dadr(int ch);
        return 8'('h14 + 4 * ch);
    endfunction

    task automatic wait_ready(int ch, output logic [31:0] d);
        d = '0;
        for (int i = 0; i < 400; i++) begin
            rd(dadr(ch), d);
            if (d[12]) break;
        end
    endtask

    task automatic wait_idle();
        logic [31:0] d;
        for (int i = 0; i < 3000; i++) begin
            rd(8'h10, d);
            if (d[0] == 1'b0) break;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int n0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(8'h04, d); chk("R1 trig", d, 0);
        rd(8'h10, d); chk("R1 status", d, 0);
        rd(8'h94, d); chk("R1 power", d, 0);
        for (int c = 0; c < 16; c++) begin
            rd(dadr(c), d); chk("R1 data", d, 0);
        end
        chk("R1 conv_start", 32'(conv_start), 0);

        // R10: unmapped and misaligned offsets
        rd(8'h00, d); chk("R10 0x00", d, 0);
        rd(8'h08, d); chk("R10 0x08", d, 0);
        rd(8'h16, d); chk("R10 0x16", d, 0);
        rd(8'h54, d); chk("R10 0x54", d, 0);
        rd(8'h90, d); chk("R10 0x90", d, 0);

        // R7: trigger while unpowered stays queued
        wr(8'h04, 32'h8);
        repeat (30) @(negedge clk);
        chk("R7 no start unpowered", 32'(n_starts), 0);
        rd(8'h10, d); chk("R6 busy while queued", d, 1);
        rd(dadr(3), d); chk("R7 no ready unpowered", d, 0);
        rd(8'h04, d); chk("R2 trig readback", d, 32'h8);

        // R7: only bit 14 of the power register is stored
        wr(8'h94, 32'hFFFF_FFFF);
        rd(8'h94, d); chk("R7 power readback", d, 32'h4000);
        wait_ready(3, d);
        chk("R7 queued request served", d, {19'b0, 1'b1, exp_data(3, 0)});
        wait_idle();
        rd(8'h10, d); chk("R6 idle after service", d, 0);

        // R2 R5: sweep every channel with the drop/raise handshake
        salt = 'h35;
        for (int c = 0; c < 16; c++) begin
            int prev;
            prev = (c == 0) ? 3 : c - 1;
            wr(8'h04, 32'h0);
            rd(dadr(prev), d); chk("R4 ready cleared", 32'(d[12]), 0);
            n0 = n_starts;
            wr(8'h04, 32'(1) << c);
            wait_ready(c, d);
            chk("R5 sweep data", d, {19'b0, 1'b1, exp_data(c, 'h35)});
            chk("R2 one start", 32'(n_starts - n0), 1);
            chk("R9 start channel", 32'(start_log[n0 % 64]), 32'(c));
        end

        // R3: writes to a data register are ignored
        wr(dadr(15), 32'h0);
        rd(dadr(15), d); chk("R3 write ignored", d, {19'b0, 1'b1, exp_data(15, 'h35)});
        wr(dadr(4), 32'hFFFF_FFFF);
        rd(dadr(4), d); chk("R3 write ignored other", d, {20'b0, exp_data(4, 'h35)});

        // R8: all channels queued at once are served lowest first
        salt = 'h7A;
        wr(8'h04, 32'h0);
        wr(8'h94, 32'h0);
        wr(8'h04, 32'hFFFF);
        rd(8'h10, d); chk("R6 busy all queued", d, 1);
        n0 = n_starts;
        wr(8'h94, 32'h4000);
        wait_idle();
        chk("R8 start count", 32'(n_starts - n0), 16);
        for (int c = 0; c < 16; c++) begin
            chk("R8 order", 32'(start_log[(n0 + c) % 64]), 32'(c));
            rd(dadr(c), d); chk("R8 data", d, {19'b0, 1'b1, exp_data(c, 'h7A)});
        end

        // R4: withdrawing a queued request cancels it
        wr(8'h04, 32'h0);
        wr(8'h94, 32'h0);
        wr(8'h04, 32'h24);
        wr(8'h04, 32'h04);
        n0 = n_starts;
        wr(8'h94, 32'h4000);
        wait_idle();
        chk("R4 only one start", 32'(n_starts - n0), 1);
        chk("R4 served channel", 32'(start_log[n0 % 64]), 2);
        rd(dadr(5), d); chk("R4 withdrawn not ready", d, {20'b0, exp_data(5, 'h7A)});

        // R5: dropping the trigger mid-conversion discards the result
        lat  = 40;
        salt = 'h11;
        wr(8'h04, 32'h0);
        n0 = n_starts;
        wr(8'h04, 32'h80);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (n_starts != n0) break;
        end
        rd(8'h10, d); chk("R6 busy in flight", d, 1);
        wr(8'h04, 32'h0);
        repeat (60) @(negedge clk);
        rd(dadr(7), d); chk("R5 discarded", d, {20'b0, exp_data(7, 'h7A)});
        rd(8'h10, d); chk("R6 idle after discard", d, 0);
        wr(8'h04, 32'h80);
        wait_ready(7, d);
        chk("R5 fresh result", d, {19'b0, 1'b1, exp_data(7, 'h11)});

        // R9: start pulses were one cycle wide
        chk("R9 pulse width", 32'(max_run), 1);

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule